// File: doc/BRIEF.md
# Wavetable Voice Envelope Generator

This block produces the attenuation envelope for one voice of a sample-playback synthesizer. It advances on each output-sample tick. A free-running global envelope counter decides, per rate, which ticks carry an update and how large that update is. The block keeps a 10-bit attenuation, where 0 is full level and 511 is silence, and a phase. The phase is one of: off, attack, first decay, sustain decay, release, pseudo-reverb or damp.

Each phase takes a 4-bit raw rate from its own register. The raw rate is scaled by a signed octave, a rate-correction value and the top F-number bit to give a 6-bit effective rate. The update interval and an eight-step increment pattern both come from that effective rate. Attack approaches zero along an exponential curve. The other phases add the increment directly. Key-on, key-off and damp commands move the voice between phases. The active flag tells the voice allocator when the voice has faded out.

Top module: `env_voice`

## Requirements
- R1: After reset the phase is off, the attenuation is 511 and active is 0. In the off phase ticks change nothing.
- R2: Effective rate: a raw value of 0 gives 0 and a raw value of 15 gives 63. When rate correction equals 15 the rate is raw*4. Otherwise the rate is (octave read as signed 4-bit + correction)*2 + F-number bit + raw*4, clamped to 0..63.
- R3: In attack, first decay, sustain decay and release, an effective rate below 4 leaves the attenuation unchanged.
- R4: Updates happen only on cycles with tick high. They also require the low s bits of the counter to be zero, where s = 12 - rate/4 for rates below 48 and s = 0 otherwise. The increment uses j = (counter >> s) mod 8. Rates below 52 give 1 or 0 from bit j of the mask AA/BA/EE/FE (hex), selected by rate mod 4. Rates 52..55 give b=1 and rates 56..59 give b=2; each gives b plus b when bit j of the mask 00/88/AA/EE (selected by rate mod 4) is set. Rates 60..63 give 4.
- R5: In attack the attenuation becomes att + ((-att-1)*inc >> 3), using an arithmetic shift. At 0 or below it is set to 0, and the phase moves to first decay when the decay level index is nonzero, or to sustain decay otherwise.
- R6: First decay adds the increment and moves to sustain decay once the attenuation reaches the decay level. The decay level is index*16, except that index 15 gives 496.
- R7: In first decay, sustain decay and release, an update that leaves the sum above 96 while reverb is enabled moves the phase to pseudo-reverb. The attenuation is limited to 511.
- R8: Sustain decay and release add the increment. On reaching 511 they hold 511 and clear active.
- R9: Pseudo-reverb uses the effective rate of raw value 5. Damp uses rate 56 and skips the below-4 rule. Both add the increment, hold at 511 and clear active there.
- R10: Damp forces the damp phase. Otherwise key-on sets attack and active and keeps the attenuation. Otherwise key-off moves an active voice to release unless it is in pseudo-reverb. A cycle that carries a command makes no tick update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Output-sample tick, one envelope step |
| eg_cnt | input | CNT_W | Global envelope counter value |
| key_on | input | 1 | Start the note (attack) |
| key_off | input | 1 | Release the note |
| damp | input | 1 | Force fast damp |
| atk_rate | input | 4 | Raw attack rate |
| dcy1_rate | input | 4 | Raw first decay rate |
| dcy_level | input | 4 | Decay level index |
| dcy2_rate | input | 4 | Raw sustain decay rate |
| rel_rate | input | 4 | Raw release rate |
| rate_corr | input | 4 | Rate correction (15 disables scaling) |
| octave | input | 4 | Signed octave |
| fnum_hi | input | 1 | Top bit of the F-number |
| reverb_en | input | 1 | Pseudo-reverb enable |
| att | output | 10 | Attenuation, 0 loud, 511 silent |
| active | output | 1 | Voice still sounding |

## Verification
The phase is not visible at the ports. A wrong phase, rate or increment therefore shows only as an attenuation path that leaves the expected one. This happens at the first update the counter grants after the fault, one cycle after that tick is presented. Fast rates expose a fault within a handful of ticks. A missed end of a phase shows either as the active flag staying high at 511 or as a step of the wrong size. The bench therefore compares attenuation and active on every cycle against a model that steps the same counter. It runs swept register settings and also drives chosen counter values at the shift and pattern boundaries.

// File: rtl/env_pkg.sv
package env_pkg;
    localparam int ATT_W     = 10;
    localparam int RAW_W     = 4;
    localparam int RATE_W    = 6;
    localparam int ATT_MAX   = 511;
    localparam int REV_LIMIT = 96;
    localparam int REV_RAW   = 5;
    localparam int DMP_RATE  = 56;
    localparam int RATE_MIN  = 4;

    typedef enum logic [2:0] {
        PH_OFF, PH_ATK, PH_DC1, PH_DC2, PH_REL, PH_REV, PH_DMP
    } phase_t;

    typedef struct packed {
        phase_t           ph;
        logic [ATT_W-1:0] att;
        logic             act;
    } env_t;

    // decay target: 16 units per 3 dB step, top index jumps to 496
    function automatic logic [ATT_W-1:0] level_of(input logic [RAW_W-1:0] idx);
        if (idx == {RAW_W{1'b1}})
            return ATT_W'(31 * 16);
        return ATT_W'({idx, 4'b0000});
    endfunction
endpackage

// File: rtl/env_rate.sv
module env_rate
    import env_pkg::*;
(
    input  logic [RAW_W-1:0]  raw,
    input  logic [RAW_W-1:0]  corr,
    input  logic [RAW_W-1:0]  octave,
    input  logic              fnum_hi,
    output logic [RATE_W-1:0] rate
);
    logic signed [7:0] oct_s, corr_s, raw_s, fn_s, acc;

    always_comb begin
        oct_s  = {{4{octave[3]}}, octave};
        corr_s = {4'b0000, corr};
        raw_s  = {4'b0000, raw};
        fn_s   = {7'd0, fnum_hi};
        acc    = ((oct_s + corr_s) <<< 1) + fn_s + (raw_s <<< 2);
        if (raw == '0)
            rate = '0;
        else if (raw == {RAW_W{1'b1}})
            rate = {RATE_W{1'b1}};
        else if (corr == {RAW_W{1'b1}})
            rate = {raw, 2'b00};
        else if (acc < 0)
            rate = '0;
        else if (acc > 8'sd63)
            rate = {RATE_W{1'b1}};
        else
            rate = acc[RATE_W-1:0];
    end
endmodule

// File: rtl/env_step.sv
module env_step
    import env_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [RATE_W-1:0] rate,
    input  logic [CNT_W-1:0]  cnt,
    output logic              fire,
    output logic [3:0]        inc
);
    logic [3:0]       shift;
    logic [CNT_W-1:0] low_mask;
    logic [2:0]       j;
    logic             lo_bit, hi_bit;
    logic [3:0]       base;

    always_comb begin
        shift    = (rate >= RATE_W'(48)) ? 4'd0 : (4'd12 - rate[5:2]);
        low_mask = ~({CNT_W{1'b1}} << shift);
        fire     = ((cnt & low_mask) == '0);
        j        = 3'(cnt >> shift);
        case (rate[1:0])
            2'd0: begin lo_bit = j[0];                         hi_bit = 1'b0; end
            2'd1: begin lo_bit = j[0] | (j == 3'd4);           hi_bit = (j[1:0] == 2'd3); end
            2'd2: begin lo_bit = j[0] | (j[1:0] == 2'd2);      hi_bit = j[0]; end
            default: begin lo_bit = (j != 3'd0);              hi_bit = (j[1:0] != 2'd0); end
        endcase
        base = (rate >= RATE_W'(56)) ? 4'd2 : 4'd1;
        if (rate >= RATE_W'(60))
            inc = 4'd4;
        else if (rate >= RATE_W'(52))
            inc = hi_bit ? (base << 1) : base;
        else
            inc = {3'b000, lo_bit};
    end
endmodule

// File: rtl/env_voice.sv
module env_voice
    import env_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] eg_cnt,
    input  logic             key_on,
    input  logic             key_off,
    input  logic             damp,
    input  logic [3:0]       atk_rate,
    input  logic [3:0]       dcy1_rate,
    input  logic [3:0]       dcy_level,
    input  logic [3:0]       dcy2_rate,
    input  logic [3:0]       rel_rate,
    input  logic [3:0]       rate_corr,
    input  logic [3:0]       octave,
    input  logic             fnum_hi,
    input  logic             reverb_en,
    output logic [9:0]       att,
    output logic             active
);
    localparam int SUM_W = ATT_W + 1;
    localparam int PRD_W = ATT_W + 4;
    localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(ATT_MAX);
    localparam logic [SUM_W-1:0] SUM_REV = SUM_W'(REV_LIMIT);

    env_t env_d, env_q;

    logic [RAW_W-1:0]  raw_sel;
    logic [RATE_W-1:0] rate_r, rate_eff;
    logic              fire, rate_ok;
    logic [3:0]        inc;
    logic [SUM_W-1:0]  sum;
    logic [PRD_W-1:0]  prod, drop;
    logic [ATT_W-1:0]  dl_lvl;

    always_comb begin
        case (env_q.ph)
            PH_ATK:  raw_sel = atk_rate;
            PH_DC1:  raw_sel = dcy1_rate;
            PH_DC2:  raw_sel = dcy2_rate;
            PH_REL:  raw_sel = rel_rate;
            PH_REV:  raw_sel = RAW_W'(REV_RAW);
            default: raw_sel = '0;
        endcase
    end

    env_rate u_rate (
        .raw     (raw_sel),
        .corr    (rate_corr),
        .octave  (octave),
        .fnum_hi (fnum_hi),
        .rate    (rate_r)
    );

    assign rate_eff = (env_q.ph == PH_DMP) ? RATE_W'(DMP_RATE) : rate_r;

    env_step #(.CNT_W(CNT_W)) u_step (
        .rate (rate_eff),
        .cnt  (eg_cnt),
        .fire (fire),
        .inc  (inc)
    );

    always_comb begin
        env_d   = env_q;
        dl_lvl  = level_of(dcy_level);
        rate_ok = (env_q.ph == PH_REV) || (env_q.ph == PH_DMP) ||
                  (rate_r >= RATE_W'(RATE_MIN));
        sum     = {1'b0, env_q.att} + {{(SUM_W-4){1'b0}}, inc};
        prod    = ({4'b0000, env_q.att} + PRD_W'(1)) * {{(PRD_W-4){1'b0}}, inc};
        drop    = (prod + PRD_W'(7)) >> 3;

        if (damp) begin
            env_d.ph = PH_DMP;
        end else if (key_on) begin
            env_d.ph  = PH_ATK;
            env_d.act = 1'b1;
        end else if (key_off) begin
            if (env_q.act && env_q.ph != PH_REV)
                env_d.ph = PH_REL;
        end else if (tick && fire && rate_ok) begin
            case (env_q.ph)
                PH_ATK: begin
                    if (drop >= {4'b0000, env_q.att}) begin
                        env_d.att = '0;
                        env_d.ph  = (dcy_level != '0) ? PH_DC1 : PH_DC2;
                    end else begin
                        env_d.att = env_q.att - drop[ATT_W-1:0];
                    end
                end
                PH_DC1: begin
                    env_d.att = sum[ATT_W-1:0];
                    if (reverb_en && sum > SUM_REV)
                        env_d.ph = PH_REV;
                    else if (sum >= {1'b0, dl_lvl})
                        env_d.ph = PH_DC2;
                end
                PH_DC2, PH_REL: begin
                    if (reverb_en && sum > SUM_REV) begin
                        env_d.ph  = PH_REV;
                        env_d.att = (sum > SUM_MAX) ? ATT_W'(ATT_MAX) : sum[ATT_W-1:0];
                    end else if (sum >= SUM_MAX) begin
                        env_d.att = ATT_W'(ATT_MAX);
                        env_d.act = 1'b0;
                    end else begin
                        env_d.att = sum[ATT_W-1:0];
                    end
                end
                PH_REV, PH_DMP: begin
                    if (sum >= SUM_MAX) begin
                        env_d.att = ATT_W'(ATT_MAX);
                        env_d.act = 1'b0;
                    end else begin
                        env_d.att = sum[ATT_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            env_q.ph  <= PH_OFF;
            env_q.att <= ATT_W'(ATT_MAX);
            env_q.act <= 1'b0;
        end else begin
            env_q <= env_d;
        end
    end

    assign att    = env_q.att;
    assign active = env_q.act;

    logic no_cmd;
    assign no_cmd = !damp && !key_on && !key_off;

    assert_att_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        env_q.att <= ATT_W'(ATT_MAX));

    assert_fall_at_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(env_q.act) |-> env_q.att == ATT_W'(ATT_MAX));

    assert_key_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on && !damp) |=> (env_q.act && env_q.ph == PH_ATK));

    assert_damp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        damp |=> env_q.ph == PH_DMP);

    assert_rev_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (env_q.ph == PH_REV && key_off && !key_on && !damp) |=> env_q.ph == PH_REV);

    assert_attack_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (env_q.ph == PH_ATK && no_cmd) |=> env_q.att <= $past(env_q.att));

    assert_idle_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && no_cmd) |=> ($stable(env_q.att) && $stable(env_q.act)));

    assert_slow_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (no_cmd && rate_r < RATE_W'(RATE_MIN) &&
         (env_q.ph == PH_ATK || env_q.ph == PH_DC1 ||
          env_q.ph == PH_DC2 || env_q.ph == PH_REL)) |=> $stable(env_q.att));

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (env_q.ph == PH_OFF && no_cmd) |=> ($stable(env_q.att) && $stable(env_q.act)));
endmodule

// File: tb/tb_env_voice.sv
`timescale 1ns/1ps
module tb_env_voice;
    localparam int CW = 16;
    localparam int S_OFF = 0, S_ATK = 1, S_DC1 = 2, S_DC2 = 3, S_REL = 4, S_REV = 5, S_DMP = 6;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic key_on = 1'b0, key_off = 1'b0, damp = 1'b0, fnum_hi = 1'b0, reverb_en = 1'b0;
    logic [CW-1:0] eg_cnt = '0;
    logic [3:0] atk_rate = 0, dcy1_rate = 0, dcy_level = 0, dcy2_rate = 0;
    logic [3:0] rel_rate = 0, rate_corr = 0, octave = 0;
    logic [9:0] att;
    logic active;

    always #10 clk = ~clk;

    env_voice #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .eg_cnt(eg_cnt),
        .key_on(key_on), .key_off(key_off), .damp(damp),
        .atk_rate(atk_rate), .dcy1_rate(dcy1_rate), .dcy_level(dcy_level),
        .dcy2_rate(dcy2_rate), .rel_rate(rel_rate), .rate_corr(rate_corr),
        .octave(octave), .fnum_hi(fnum_hi), .reverb_en(reverb_en),
        .att(att), .active(active)
    );

    int errors = 0, checks = 0, tick_no = 0;
    bit done = 0;
    int m_ph = S_OFF, m_att = 511;
    bit m_act = 0;

    task automatic chk(string tag, int got, int exp_v, string what);
        checks++;
        if (got !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp_v);
        end
    endtask

    function automatic int erate(int raw);
        int o, v;
        if (raw == 0) return 0;
        if (raw == 15) return 63;
        if (rate_corr == 15) return raw * 4;
        o = (octave >= 8) ? int'(octave) - 16 : int'(octave);
        v = (o + int'(rate_corr)) * 2 + int'(fnum_hi) + raw * 4;
        if (v < 0) return 0;
        if (v > 63) return 63;
        return v;
    endfunction

    function automatic int incf(int r, int j);
        int lo [4];
        int hi [4];
        int b;
        lo = '{170, 186, 238, 254};
        hi = '{0, 136, 170, 238};
        if (r >= 60) return 4;
        if (r >= 52) begin
            b = (r >= 56) ? 2 : 1;
            return b + (((hi[r % 4] >> j) & 1) * b);
        end
        return (lo[r % 4] >> j) & 1;
    endfunction

    function automatic int dlv(int i);
        return (i == 15) ? 496 : i * 16;
    endfunction

    task automatic m_step(bit t, bit kon, bit koff, bit dmp);
        int raw, r, sh, j, inc, s;
        bit ok;
        if (dmp) m_ph = S_DMP;
        else if (kon) begin m_ph = S_ATK; m_act = 1; end
        else if (koff) begin if (m_act && m_ph != S_REV) m_ph = S_REL; end
        else if (t && m_ph != S_OFF) begin
            case (m_ph)
                S_ATK: raw = atk_rate;
                S_DC1: raw = dcy1_rate;
                S_DC2: raw = dcy2_rate;
                S_REL: raw = rel_rate;
                default: raw = 5;
            endcase
            r  = (m_ph == S_DMP) ? 56 : erate(raw);
            ok = (m_ph == S_REV || m_ph == S_DMP) || r >= 4;
            sh = (r >= 48) ? 0 : 12 - r / 4;
            if (ok && (int'(eg_cnt) % (1 << sh)) == 0) begin
                j = (int'(eg_cnt) >> sh) % 8;
                inc = incf(r, j);
                if (m_ph == S_ATK) begin
                    m_att = m_att + (((~m_att) * inc) >>> 3);
                    if (m_att <= 0) begin
                        m_att = 0;
                        m_ph = (dcy_level != 0) ? S_DC1 : S_DC2;
                    end
                end else begin
                    s = m_att + inc;
                    if (m_ph != S_REV && m_ph != S_DMP && reverb_en && s > 96) begin
                        m_ph = S_REV;
                        m_att = (s > 511) ? 511 : s;
                    end else if (m_ph == S_DC1) begin
                        m_att = s;
                        if (s >= dlv(dcy_level)) m_ph = S_DC2;
                    end else if (s >= 511) begin
                        m_att = 511; m_act = 0;
                    end else m_att = s;
                end
            end
        end
    endtask

    task automatic cyc(bit t, bit kon, bit koff, bit dmp, string tag);
        int old;
        string tg;
        tick = t; key_on = kon; key_off = koff; damp = dmp;
        old = m_ph;
        m_step(t, kon, koff, dmp);
        @(posedge clk);
        @(negedge clk);
        tg = tag;
        if (tg == "") begin
            if (m_ph == S_REV && old != S_REV) tg = "R7";
            else case (old)
                S_ATK: tg = "R5";
                S_DC1: tg = "R6";
                S_DC2, S_REL: tg = "R8";
                S_REV, S_DMP: tg = "R9";
                default: tg = "R1";
            endcase
        end
        chk(tg, int'(att), m_att, "att");
        chk(tg, int'(active), int'(m_act), "active");
        key_on = 0; key_off = 0; damp = 0;
        if (t) eg_cnt = eg_cnt + 1'b1;
    endtask

    task automatic run(int n, string tag);
        for (int k = 0; k < n; k++) begin
            tick_no++;
            cyc((tick_no % 7) != 3, 0, 0, 0, tag);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R10: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(att), 511, "reset att");
        chk("R1", int'(active), 0, "reset active");
        run(20, "R1");

        // fastest attack, no decay level: 511 -> 255 on first tick
        atk_rate = 15; rate_corr = 15; dcy_level = 0; dcy2_rate = 0;
        cyc(1, 1, 0, 0, "R10");
        chk("R10", int'(att), 511, "key on keeps att");
        cyc(1, 0, 0, 0, "R5");
        chk("R5", int'(att), 255, "first attack step");
        run(20, "");
        chk("R5", int'(att), 0, "attack end");
        run(60, "R3");
        chk("R3", int'(att), 0, "sustain decay rate 0 frozen");
        rel_rate = 15;
        cyc(1, 0, 1, 0, "R10");
        run(200, "");
        chk("R8", int'(active), 0, "release ends inactive");

        // rate scaling
        atk_rate = 13; rate_corr = 15;
        cyc(1, 1, 0, 0, "R10");
        cyc(1, 0, 0, 0, "R2");
        chk("R2", int'(att), 447, "rate 52 step");
        rate_corr = 0; octave = 7; fnum_hi = 1;
        cyc(1, 1, 0, 0, "R10");
        cyc(1, 0, 0, 0, "R2");
        chk("R2", int'(att), 223, "clamped rate 63 step");
        rate_corr = 0; octave = 8; fnum_hi = 0; atk_rate = 15;
        cyc(1, 1, 0, 0, "R10");
        cyc(1, 0, 0, 0, "R2");
        chk("R2", int'(att), 111, "raw 15 gives 63");
        cyc(1, 0, 0, 1, "R10");
        run(300, "");
        chk("R9", int'(att), 511, "damp reaches silence");

        // shift and pattern boundaries
        rate_corr = 15; atk_rate = 12;
        cyc(1, 1, 0, 0, "R10");
        eg_cnt = 16'd8;
        cyc(1, 0, 0, 0, "R4");
        chk("R4", int'(att), 511, "pattern slot 0 is zero");
        cyc(1, 0, 0, 0, "R4");
        chk("R4", int'(att), 447, "pattern slot 1 is one");
        atk_rate = 11;
        cyc(1, 0, 0, 0, "R4");
        chk("R4", int'(att), 391, "shift 1 fires on even count");
        cyc(1, 0, 0, 0, "R4");
        chk("R4", int'(att), 391, "shift 1 skips odd count");
        cyc(0, 0, 0, 0, "R4");
        chk("R4", int'(att), 391, "no tick no change");

        // scaled to rate 0 by a negative octave
        atk_rate = 1; rate_corr = 0; octave = 8; fnum_hi = 0;
        run(100, "R3");
        chk("R3", int'(att), 391, "attack rate 0 frozen");

        // pseudo-reverb, key off ignored there
        cyc(1, 0, 0, 1, "R10");
        run(300, "");
        atk_rate = 15; dcy1_rate = 15; dcy_level = 10; rate_corr = 14;
        octave = 7; fnum_hi = 1; reverb_en = 1;
        cyc(1, 1, 0, 0, "R10");
        run(50, "");
        cyc(1, 0, 1, 0, "R10");
        run(200, "");
        chk("R9", int'(active), 0, "reverb ends inactive");
        reverb_en = 0;

        // parameter sweep
        for (int i = 0; i < 40; i++) begin
            atk_rate  = 4'(10 + i % 6);
            dcy1_rate = 4'(9 + (i * 3) % 7);
            dcy_level = 4'((i * 5) % 16);
            dcy2_rate = 4'(8 + i % 8);
            rel_rate  = 4'(9 + i % 7);
            rate_corr = (i % 4 == 0) ? 4'd15 : 4'((i * 3) % 15);
            octave    = 4'((i * 7) % 16);
            fnum_hi   = 1'(i % 2);
            reverb_en = (i % 3 == 0);
            cyc(1, 1, 0, 0, "R10");
            run(1100, "");
            if (i % 4 == 1) begin
                cyc(1, 1, 0, 0, "R10");
                run(100, "");
            end
            cyc(1, 0, 1, 0, "R10");
            run(1100, "");
            if (i % 5 == 0) begin
                cyc(1, 1, 1, 1, "R10");
                run(400, "");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule